// File: doc/BRIEF.md
# I2S Serial Audio Receiver

This block takes serial audio arriving on a data line, framed by a bit clock and a word-select line, and turns each channel slot into a parallel word. Each finished word is offered on a write port that a FIFO can accept. The receiver can act as clock master, deriving the bit clock and word select from the system clock through a programmable divider. It can also act as slave, bringing an external bit clock and word select into the system clock domain through synchronizers and detecting their edges there. In slave mode the system clock must run at least four times faster than the bit clock.

Framing follows standard I2S. Data is taken MSB first on rising bit-clock edges, and the MSB of a slot arrives one bit period after the word-select transition. Several settings are held on plain input ports: the sample width, the slot length used for generated framing, the word-select polarity, mono capture, and packing of a left/right pair into one word as two 16-bit halves or two 8-bit quarters. The write port carries no backpressure. A word offered while the consumer is not ready is lost, and a sticky flag records the loss until a clear input is pulsed.

Top module: `i2s_rx_core`

## Requirements
- R1: While reset is asserted and after its release, wr_valid, ovf_flag, sck_out and ws_out are all 0.
- R2: In plain stereo mode (cfg_mono=0, cfg_compact=0), every completed slot yields one wr_data word, in arrival order. The slot's first data bit is the one taken on the second rising bit-clock edge after a word-select change, and it lands in bit 31. Later bits fill downward, and unused low bits are 0. A slot completes on the rising edge that sees the next word-select change, and the bit taken on that edge is the slot's last bit.
- R3: Bits beyond cfg_sample_m1+1 in a slot are discarded. The word keeps only the top cfg_sample_m1+1 bits, and its remaining bits read as zero.
- R4: When a slot is shorter than the sample width, only the bits actually received are kept, left-justified, and the rest are zero.
- R5: cfg_ws_pol=0 means word select high is the left channel. cfg_ws_pol=1 means word select high is the right channel.
- R6: With cfg_mono=1 and cfg_compact=0, only slots whose word-select level equals cfg_ws_pol produce a word, and all other slots are dropped.
- R7: With cfg_compact=1 and cfg_compact8=0, a left slot followed by a right slot produces one word. The word holds the top 16 bits of the left sample in bits 31:16 and the top 16 bits of the right sample in bits 15:0. A right slot with no pending left sample produces nothing.
- R8: With cfg_compact=1 and cfg_compact8=1, the packed word holds the top 8 bits of the left sample in bits 15:8 and the top 8 bits of the right sample in bits 7:0, with bits 31:16 zero.
- R9: With cfg_master=1, sck_out toggles every cfg_clk_div+1 system clocks. ws_out changes only together with a falling sck_out, after every cfg_slot_m1+1 bit-clock periods.
- R10: With cfg_master=0, the receiver frames and samples using sck_in, ws_in and sd_in only.
- R11: wr_valid is high for exactly one cycle per word. If wr_ready is low in that cycle, the word is lost and ovf_flag becomes 1 on the next cycle and stays 1 until cleared.
- R12: Pulsing ovf_clr clears ovf_flag on the next cycle. If a loss and ovf_clr happen in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: use external ones |
| cfg_ws_pol | input | 1 | Word-select polarity for channel assignment |
| cfg_mono | input | 1 | Capture a single channel |
| cfg_compact | input | 1 | Pack a left/right pair into one word |
| cfg_compact8 | input | 1 | In packed mode, 1 selects 8-bit halves, 0 selects 16-bit |
| cfg_sample_m1 | input | 5 | Sample width minus one |
| cfg_slot_m1 | input | 5 | Bit clocks per word-select phase minus one (master) |
| cfg_clk_div | input | 8 | System clocks per bit-clock half period minus one |
| sck_in | input | 1 | External bit clock |
| ws_in | input | 1 | External word select |
| sd_in | input | 1 | Serial data |
| sck_out | output | 1 | Generated bit clock |
| ws_out | output | 1 | Generated word select |
| wr_valid | output | 1 | Word strobe to the FIFO |
| wr_data | output | 32 | Received word |
| wr_ready | input | 1 | FIFO can accept a word |
| ovf_clr | input | 1 | Clears the loss flag |
| ovf_flag | output | 1 | Sticky word-loss flag |

## Verification
Two events can reach the loss flag in the same cycle: a word is dropped because wr_ready is low, and ovf_clr asks for the flag to be cleared. The bench holds ovf_clr high for a whole frame while keeping wr_ready low. It then watches the cycle right after the first wr_valid pulse and expects the flag to read 1 there, because the set wins. One cycle later it expects the flag to read 0 again, because the clear is still applied. A separate pass checks each action on its own: a loss with no clear, and a clear with no loss.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  typedef enum logic [1:0] {
    OM_PLAIN,
    OM_MONO,
    OM_PACK_HALF,
    OM_PACK_QTR
  } out_mode_e;

  function automatic out_mode_e pick_mode(input logic compact,
                                          input logic narrow,
                                          input logic mono);
    if (compact) return narrow ? OM_PACK_QTR : OM_PACK_HALF;
    return mono ? OM_MONO : OM_PLAIN;
  endfunction

endpackage

// File: rtl/i2s_rx_clkgen.sv
module i2s_rx_clkgen #(
  parameter int DIV_W = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  input  logic [IDX_W-1:0] slot_m1,
  output logic             sck,
  output logic             ws,
  output logic             rise
);

  logic [DIV_W-1:0] div_cnt_q, div_cnt_n;
  logic [IDX_W-1:0] bit_cnt_q, bit_cnt_n;
  logic             sck_q, sck_n;
  logic             ws_q, ws_n;
  logic             tick, fall;

  always_comb begin
    tick      = en && (div_cnt_q == div);
    fall      = tick && sck_q;
    rise      = tick && !sck_q;
    div_cnt_n = div_cnt_q;
    sck_n     = sck_q;
    bit_cnt_n = bit_cnt_q;
    ws_n      = ws_q;
    if (!en) begin
      div_cnt_n = '0;
      sck_n     = 1'b0;
      bit_cnt_n = '0;
      ws_n      = 1'b0;
    end else begin
      if (tick) begin
        div_cnt_n = '0;
        sck_n     = !sck_q;
      end else begin
        div_cnt_n = div_cnt_q + 1'b1;
      end
      if (fall) begin
        if (bit_cnt_q == slot_m1) begin
          bit_cnt_n = '0;
          ws_n      = !ws_q;
        end else begin
          bit_cnt_n = bit_cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt_q <= '0;
      bit_cnt_q <= '0;
      sck_q     <= 1'b0;
      ws_q      <= 1'b0;
    end else begin
      div_cnt_q <= div_cnt_n;
      bit_cnt_q <= bit_cnt_n;
      sck_q     <= sck_n;
      ws_q      <= ws_n;
    end
  end

  assign sck = sck_q;
  assign ws  = ws_q;

endmodule

// File: rtl/i2s_rx_sync_edge.sv
module i2s_rx_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic int_rise,
  input  logic int_ws,
  input  logic ext_sck,
  input  logic ext_ws,
  input  logic ext_sd,
  output logic bit_stb,
  output logic bit_ws,
  output logic bit_sd
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sck_c, ws_c, sd_c;
  logic              sck_d;
  logic              sd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_c <= '0;
      ws_c  <= '0;
      sd_c  <= '0;
      sck_d <= 1'b0;
      sd_q  <= 1'b0;
    end else begin
      sck_c[0] <= ext_sck;
      ws_c[0]  <= ext_ws;
      sd_c[0]  <= ext_sd;
      sck_d    <= sck_c[LAST];
      sd_q     <= ext_sd;
    end
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sck_c[g] <= 1'b0;
        ws_c[g]  <= 1'b0;
        sd_c[g]  <= 1'b0;
      end else begin
        sck_c[g] <= sck_c[g-1];
        ws_c[g]  <= ws_c[g-1];
        sd_c[g]  <= sd_c[g-1];
      end
    end
  end

  always_comb begin
    if (master) begin
      bit_stb = int_rise;
      bit_ws  = int_ws;
      bit_sd  = sd_q;
    end else begin
      bit_stb = sck_c[LAST] && !sck_d;
      bit_ws  = ws_c[LAST];
      bit_sd  = sd_c[LAST];
    end
  end

endmodule

// File: rtl/i2s_rx_deser.sv
module i2s_rx_deser #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              ws,
  input  logic              sd,
  input  logic [IDX_W-1:0]  sample_m1,
  output logic              done,
  output logic              done_ws,
  output logic [WORD_W-1:0] done_word
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORD_W - 1);
  localparam logic [IDX_W:0]   SAT     = (IDX_W+1)'(WORD_W);

  logic              seen_q, seen_n, armed_q, armed_n, ws_prev_q, ws_prev_n;
  logic [IDX_W:0]    idx_q, idx_n;
  logic [WORD_W-1:0] acc_q, acc_n, acc_with;
  logic              done_q, done_n, dws_q, dws_n;
  logic [WORD_W-1:0] word_q, word_n;
  logic              take;

  always_comb begin
    take     = ({1'b0, sample_m1} >= idx_q) && (idx_q < SAT);
    acc_with = acc_q;
    if (take) acc_with[TOP_IDX - idx_q[IDX_W-1:0]] = sd;

    seen_n    = seen_q;
    armed_n   = armed_q;
    ws_prev_n = ws_prev_q;
    idx_n     = idx_q;
    acc_n     = acc_q;
    done_n    = 1'b0;
    dws_n     = dws_q;
    word_n    = word_q;
    if (stb) begin
      if (!seen_q) begin
        seen_n    = 1'b1;
        ws_prev_n = ws;
      end else if (ws != ws_prev_q) begin
        if (armed_q) begin
          done_n = 1'b1;
          dws_n  = ws_prev_q;
          word_n = acc_with;
        end
        ws_prev_n = ws;
        armed_n   = 1'b1;
        idx_n     = '0;
        acc_n     = '0;
      end else if (armed_q) begin
        acc_n = acc_with;
        if (idx_q < SAT) idx_n = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      armed_q   <= 1'b0;
      ws_prev_q <= 1'b0;
      idx_q     <= '0;
      acc_q     <= '0;
      done_q    <= 1'b0;
      dws_q     <= 1'b0;
      word_q    <= '0;
    end else begin
      seen_q    <= seen_n;
      armed_q   <= armed_n;
      ws_prev_q <= ws_prev_n;
      idx_q     <= idx_n;
      acc_q     <= acc_n;
      done_q    <= done_n;
      dws_q     <= dws_n;
      word_q    <= word_n;
    end
  end

  assign done      = done_q;
  assign done_ws   = dws_q;
  assign done_word = word_q;

endmodule

// File: rtl/i2s_rx_core.sv
module i2s_rx_core #(
  parameter int WORD_W      = 32,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_master,
  input  logic                        cfg_ws_pol,
  input  logic                        cfg_mono,
  input  logic                        cfg_compact,
  input  logic                        cfg_compact8,
  input  logic [$clog2(WORD_W)-1:0]   cfg_sample_m1,
  input  logic [$clog2(WORD_W)-1:0]   cfg_slot_m1,
  input  logic [DIV_W-1:0]            cfg_clk_div,
  input  logic                        sck_in,
  input  logic                        ws_in,
  input  logic                        sd_in,
  output logic                        sck_out,
  output logic                        ws_out,
  output logic                        wr_valid,
  output logic [WORD_W-1:0]           wr_data,
  input  logic                        wr_ready,
  input  logic                        ovf_clr,
  output logic                        ovf_flag
);
  import i2s_rx_pkg::*;

  localparam int IDX_W = $clog2(WORD_W);
  localparam int HALF  = WORD_W / 2;
  localparam int QTR   = WORD_W / 4;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic              gen_rise, stb, b_ws, b_sd;
  logic              d_done, d_ws;
  logic [WORD_W-1:0] d_word;

  i2s_rx_clkgen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_clkgen (
    .clk(clk), .rst_n(rst_int_n), .en(cfg_master), .div(cfg_clk_div),
    .slot_m1(cfg_slot_m1), .sck(sck_out), .ws(ws_out), .rise(gen_rise)
  );

  i2s_rx_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .master(cfg_master), .int_rise(gen_rise),
    .int_ws(ws_out), .ext_sck(sck_in), .ext_ws(ws_in), .ext_sd(sd_in),
    .bit_stb(stb), .bit_ws(b_ws), .bit_sd(b_sd)
  );

  i2s_rx_deser #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_deser (
    .clk(clk), .rst_n(rst_int_n), .stb(stb), .ws(b_ws), .sd(b_sd),
    .sample_m1(cfg_sample_m1), .done(d_done), .done_ws(d_ws), .done_word(d_word)
  );

  out_mode_e         mode;
  logic              is_left, emit;
  logic [WORD_W-1:0] emit_data;
  logic [HALF-1:0]   held_q, held_n;
  logic              held_v_q, held_v_n;
  logic              valid_q, valid_n, ovf_q, ovf_n;
  logic [WORD_W-1:0] data_q, data_n;

  always_comb begin
    mode      = pick_mode(cfg_compact, cfg_compact8, cfg_mono);
    is_left   = d_ws ^ cfg_ws_pol;
    emit      = 1'b0;
    emit_data = d_word;
    held_n    = held_q;
    held_v_n  = cfg_compact ? held_v_q : 1'b0;
    if (d_done) begin
      unique case (mode)
        OM_PLAIN: emit = 1'b1;
        OM_MONO:  emit = (d_ws == cfg_ws_pol);
        default: begin
          if (is_left) begin
            held_n   = d_word[WORD_W-1 -: HALF];
            held_v_n = 1'b1;
          end else if (held_v_q) begin
            emit     = 1'b1;
            held_v_n = 1'b0;
            if (mode == OM_PACK_HALF)
              emit_data = {held_q, d_word[WORD_W-1 -: HALF]};
            else
              emit_data = {{HALF{1'b0}}, held_q[HALF-1 -: QTR], d_word[WORD_W-1 -: QTR]};
          end
        end
      endcase
    end
    valid_n = emit;
    data_n  = emit ? emit_data : data_q;
    if (valid_q && !wr_ready) ovf_n = 1'b1;
    else if (ovf_clr)         ovf_n = 1'b0;
    else                      ovf_n = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      held_q   <= '0;
      held_v_q <= 1'b0;
      valid_q  <= 1'b0;
      data_q   <= '0;
      ovf_q    <= 1'b0;
    end else begin
      held_q   <= held_n;
      held_v_q <= held_v_n;
      valid_q  <= valid_n;
      data_q   <= data_n;
      ovf_q    <= ovf_n;
    end
  end

  assign wr_valid = valid_q;
  assign wr_data  = data_q;
  assign ovf_flag = ovf_q;

endmodule

// File: rtl/i2s_rx_core_chk.sv
module i2s_rx_core_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_master,
  input logic              cfg_compact,
  input logic              cfg_compact8,
  input logic              sck_out,
  input logic              ws_out,
  input logic              wr_valid,
  input logic [WORD_W-1:0] wr_data,
  input logic              wr_ready,
  input logic              ovf_clr,
  input logic              ovf_flag
);

  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R11
  loss_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf_flag);

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R12
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(wr_valid && !wr_ready)) |=> !ovf_flag);

  // R8
  narrow_pack_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && cfg_compact && cfg_compact8) |-> (wr_data[WORD_W-1:WORD_W/2] == '0));

  // R9
  ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && $past(cfg_master) && !$stable(ws_out)) |-> $fell(sck_out));

endmodule

bind i2s_rx_core i2s_rx_core_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_compact(cfg_compact),
  .cfg_compact8(cfg_compact8), .sck_out(sck_out), .ws_out(ws_out),
  .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
  .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
);

// File: tb/i2s_rx_core_bench.sv
module i2s_rx_core_bench;

  typedef struct packed {
    logic        pol;
    logic        mono;
    logic        cmp;
    logic        c8;
    logic [4:0]  smp;
    logic [4:0]  slt;
    logic [31:0] l;
    logic [31:0] r;
    logic [1:0]  n;
    logic [31:0] e0;
    logic [31:0] e1;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // R2 R10 plain stereo, full width
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd31, 5'd31, 32'hA5A50F0F, 32'h12345678, 2'd2, 32'hA5A50F0F, 32'h12345678},
    // R3 16-bit sample in a 32-bit slot
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd15, 5'd31, 32'hDEADBEEF, 32'hCAFEF00D, 2'd2, 32'hDEAD0000, 32'hCAFE0000},
    // R4 8-bit slot, 32-bit sample
    '{1'b0, 1'b0, 1'b0, 1'b0, 5'd31, 5'd7,  32'hF0F0F0F0, 32'h0F0F0F0F, 2'd2, 32'hF0000000, 32'h0F000000},
    // R5 R7 inverted polarity, 16-bit packing
    '{1'b1, 1'b0, 1'b1, 1'b0, 5'd15, 5'd15, 32'h5A5A0000, 32'hC3C30000, 2'd1, 32'h5A5AC3C3, 32'h0},
    // R6 mono, polarity 0
    '{1'b0, 1'b1, 1'b0, 1'b0, 5'd31, 5'd31, 32'h11111111, 32'h87654321, 2'd1, 32'h87654321, 32'h0},
    // R6 mono, polarity 1, 24-bit sample
    '{1'b1, 1'b1, 1'b0, 1'b0, 5'd23, 5'd31, 32'h22222222, 32'h0F1E2D3C, 2'd1, 32'h0F1E2D00, 32'h0},
    // R7 16-bit packing, polarity 0
    '{1'b0, 1'b0, 1'b1, 1'b0, 5'd15, 5'd15, 32'hBEEF0000, 32'h12340000, 2'd1, 32'hBEEF1234, 32'h0},
    // R8 8-bit packing
    '{1'b0, 1'b0, 1'b1, 1'b1, 5'd7,  5'd15, 32'h9C5A0000, 32'h3E770000, 2'd1, 32'h00009C3E, 32'h0},
    // R5 inverted polarity, plain stereo, 24-bit
    '{1'b1, 1'b0, 1'b0, 1'b0, 5'd23, 5'd23, 32'hABCDEF12, 32'h13579BDF, 2'd2, 32'hABCDEF00, 32'h13579B00}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R2/R10";
      1: return "R3";
      2: return "R4";
      3: return "R5/R7";
      4: return "R6";
      5: return "R6 pol1";
      6: return "R7";
      7: return "R8";
      default: return "R5 stereo";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_master = 1'b0, cfg_ws_pol = 1'b0, cfg_mono = 1'b0;
  logic       cfg_compact = 1'b0, cfg_compact8 = 1'b0;
  logic [4:0] cfg_sample_m1 = 5'd31, cfg_slot_m1 = 5'd31;
  logic [7:0] cfg_clk_div = 8'd0;
  logic       sck_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0;
  logic       sck_out, ws_out, wr_valid, ovf_flag;
  logic [31:0] wr_data;
  logic       wr_ready = 1'b1, ovf_clr = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int cap_total = 0;
  logic [31:0] cap [64];
  logic timed_out = 1'b0;

  always #10 clk = ~clk;

  i2s_rx_core u_i2s_rx_core (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_ws_pol(cfg_ws_pol),
    .cfg_mono(cfg_mono), .cfg_compact(cfg_compact), .cfg_compact8(cfg_compact8),
    .cfg_sample_m1(cfg_sample_m1), .cfg_slot_m1(cfg_slot_m1), .cfg_clk_div(cfg_clk_div),
    .sck_in(sck_in), .ws_in(ws_in), .sd_in(sd_in), .sck_out(sck_out), .ws_out(ws_out),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .ovf_clr(ovf_clr), .ovf_flag(ovf_flag)
  );

  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      cap[cap_total % 64] <= wr_data;
      cap_total <= cap_total + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic bit_period(input logic w, input logic d);
    @(negedge clk);
    sck_in = 1'b0;
    ws_in  = w;
    sd_in  = d;
    repeat (4) @(negedge clk);
    sck_in = 1'b1;
    repeat (4) @(negedge clk);
    sck_in = 1'b0;
  endtask

  task automatic send_pair(input logic pol, input int s, input logic [31:0] l, input logic [31:0] r);
    logic wl, wr;
    wl = ~pol;
    wr = pol;
    bit_period(wr, 1'b0);
    bit_period(wr, 1'b0);
    for (int k = 0; k < s; k++) bit_period(wl, (k == 0) ? 1'b0 : l[32-k]);
    for (int k = 0; k < s; k++) bit_period(wr, (k == 0) ? l[32-s] : r[32-k]);
    bit_period(wl, r[32-s]);
    repeat (12) @(negedge clk);
  endtask

  task automatic apply_vec(input vec_t v);
    cfg_master    = 1'b0;
    cfg_ws_pol    = v.pol;
    cfg_mono      = v.mono;
    cfg_compact   = v.cmp;
    cfg_compact8  = v.c8;
    cfg_sample_m1 = v.smp;
    cfg_slot_m1   = v.slt;
  endtask

  task automatic run_tests();
    int base;
    int cnt;
    vec_t v;

    // R1 reset state
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 wr_valid in reset", {31'b0, wr_valid}, 32'd0);
    check("R1 ovf_flag in reset", {31'b0, ovf_flag}, 32'd0);
    check("R1 sck_out in reset", {31'b0, sck_out}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 ws_out after reset", {31'b0, ws_out}, 32'd0);
    check("R1 wr_valid after reset", {31'b0, wr_valid}, 32'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      apply_vec(v);
      do_reset();
      base = cap_total;
      send_pair(v.pol, int'(v.slt) + 1, v.l, v.r);
      check({vec_tag(i), " word count"}, 32'(cap_total - base), {30'b0, v.n});
      if (v.n >= 2'd1) check({vec_tag(i), " first word"}, cap[base % 64], v.e0);
      if (v.n == 2'd2) check({vec_tag(i), " second word"}, cap[(base + 1) % 64], v.e1);
    end

    // R11 loss with ready low
    apply_vec(VECS[0]);
    do_reset();
    wr_ready = 1'b0;
    base = cap_total;
    send_pair(1'b0, 32, 32'h13572468, 32'h24681357);
    check("R11 no accepted words", 32'(cap_total - base), 32'd0);
    check("R11 loss flag set", {31'b0, ovf_flag}, 32'd1);
    wr_ready = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 loss flag sticky", {31'b0, ovf_flag}, 32'd1);

    // R12 plain clear
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R12 flag cleared", {31'b0, ovf_flag}, 32'd0);

    // R12 loss and clear together: set wins
    wr_ready = 1'b0;
    ovf_clr  = 1'b1;
    fork
      send_pair(1'b0, 32, 32'h0F0F1234, 32'h55AA55AA);
      begin
        while (wr_valid !== 1'b1) @(negedge clk);
        @(negedge clk);
        check("R12 set wins over clear", {31'b0, ovf_flag}, 32'd1);
        @(negedge clk);
        check("R12 clear applies afterwards", {31'b0, ovf_flag}, 32'd0);
      end
    join
    ovf_clr  = 1'b0;
    wr_ready = 1'b1;

    // R9 master clock generation
    cfg_master    = 1'b1;
    cfg_ws_pol    = 1'b0;
    cfg_mono      = 1'b0;
    cfg_compact   = 1'b0;
    cfg_compact8  = 1'b0;
    cfg_clk_div   = 8'd1;
    cfg_slot_m1   = 5'd3;
    cfg_sample_m1 = 5'd3;
    sd_in  = 1'b1;
    sck_in = 1'b0;
    ws_in  = 1'b0;
    do_reset();
    base = cap_total;
    while (sck_out !== 1'b0) @(negedge clk);
    while (sck_out !== 1'b1) @(negedge clk);
    cnt = 0;
    while (sck_out !== 1'b0) begin @(negedge clk); cnt++; end
    while (sck_out !== 1'b1) begin @(negedge clk); cnt++; end
    check("R9 bit clock period", 32'(cnt), 32'd4);
    while (ws_out !== 1'b0) @(negedge clk);
    while (ws_out !== 1'b1) @(negedge clk);
    cnt = 0;
    while (ws_out !== 1'b0) begin @(negedge clk); cnt++; end
    check("R9 word select half period", 32'(cnt), 32'd16);
    repeat (100) @(negedge clk);
    check("R9 master words produced", {31'b0, (cap_total - base) >= 2}, 32'd1);
    check("R9 master word content", cap[(cap_total - 1) % 64], 32'hF0000000);
    cfg_master = 1'b0;
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule